// File: doc/BRIEF.md
# Oscillator-Sampled Entropy Collector

This block turns a bank of free-running oscillator outputs into random words. The oscillator levels arrive as one input vector. A sampling tick fires once every `SAMPLE_PERIOD` clock cycles. On each tick the block folds all oscillator levels into a single parity bit. Every two ticks it XORs the pair of parity bits into one entropy bit. That bit shifts into the low end of a word register, and the oldest bit falls off the top.

Harvesting never pauses. Software reads the block through a two-register read port, with a status word and a data word. It polls the status word until the ready bit is set and then reads the data word. Reading the data word consumes the word: ready drops, and it rises again only after a full word's worth of new bits has arrived. The oscillator vector passes through a configurable synchronizer before it is sampled.

Top module: `osc_entropy_harvester`

## Requirements
- R1: After reset, `rd_data` is zero and a status read returns zero, so ready is clear.
- R2: A sampling tick fires every `SAMPLE_PERIOD` cycles. On each tick the sampled value is the XOR of all `NUM_OSC` synchronized oscillator levels.
- R3: Each entropy bit is the XOR of two consecutive tick samples. Every second tick produces one bit, so a stream of odd-parity samples yields only zero bits.
- R4: Each entropy bit enters word bit 0 and the older bits move up one place. Bit `WORD_W-1` is discarded.
- R5: Status bit 0 (select 0) is the ready flag and the remaining status bits read as zero. Ready is set once `WORD_W` entropy bits have arrived since reset or since the last data read.
- R6: A data read (select 1) returns the word as it stood before that clock edge. It clears ready and restarts the fresh-bit count at zero. A bit arriving on that same edge is shifted in but not counted.
- R7: Collection continues while ready is set. A later data read returns the newest bits.
- R8: A status read does not change the ready flag or the word.
- R9: `rd_data` loads on the clock edge where `rd_en` is high and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_in | input | NUM_OSC | Free-running oscillator levels |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Register select: 0 status, 1 data |
| rd_data | output | WORD_W | Read result, registered |

## Verification
A read result is due one edge after the `rd_en` edge. The bench compares `rd_data` at the following falling edge against a bench-side model that is stepped on every rising edge. The model applies the same timing chain as the requirements:
- `SYNC_STAGES` cycles of synchronizer delay;
- a tick on every `SAMPLE_PERIOD`-th edge;
- one cycle from the second tick of a pair to the bit strobe;
- one cycle from that strobe to the word and ready update.

Directed runs with constant oscillator patterns have a fixed all-zero expected word. Those checks wait well past the settling window before they read.

// File: rtl/oeh_pkg.sv
package oeh_pkg;
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_DATA   = 1'b1
   } oeh_sel_e;

   localparam int unsigned STATUS_READY_BIT = 0;
endpackage

// File: rtl/oeh_sample_timer.sv
module oeh_sample_timer #(
   parameter int unsigned SAMPLE_PERIOD = 4096
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = (SAMPLE_PERIOD > 2) ? $clog2(SAMPLE_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/oeh_osc_sampler.sv
module oeh_osc_sampler #(
   parameter int unsigned NUM_OSC     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OSC-1:0] osc_in,
   input  logic               tick,
   output logic               bit_vld,
   output logic               bit_val
);
   logic [NUM_OSC-1:0] osc_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign osc_s = osc_in;
      end else begin : g_sync
         logic [NUM_OSC-1:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= osc_in;
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign osc_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   logic parity;
   logic second_q;
   logic first_q;

   assign parity = ^osc_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         first_q  <= 1'b0;
         bit_vld  <= 1'b0;
         bit_val  <= 1'b0;
      end else begin
         bit_vld <= tick && second_q;
         if (tick) begin
            second_q <= !second_q;
            if (second_q) begin
               bit_val <= first_q ^ parity;
            end else begin
               first_q <= parity;
            end
         end
      end
   end
endmodule

// File: rtl/oeh_word_collector.sv
module oeh_word_collector #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              consume,
   output logic [WORD_W-1:0] word,
   output logic              ready
);
   localparam int unsigned FW = $clog2(WORD_W + 1);
   localparam logic [FW-1:0] FULL = FW'(WORD_W);

   logic [FW-1:0] fresh_q;

   assign ready = (fresh_q == FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word    <= '0;
         fresh_q <= '0;
      end else begin
         if (bit_vld) begin
            word <= {word[WORD_W-2:0], bit_val};
         end
         if (consume) begin
            fresh_q <= '0;
         end else if (bit_vld && !ready) begin
            fresh_q <= fresh_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/osc_entropy_harvester.sv
module osc_entropy_harvester
   import oeh_pkg::*;
#(
   parameter int unsigned NUM_OSC       = 32,
   parameter int unsigned SAMPLE_PERIOD = 4096,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned WORD_W        = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OSC-1:0] osc_in,
   input  logic               rd_en,
   input  logic               rd_sel,
   output logic [WORD_W-1:0]  rd_data
);
   generate
      if (SAMPLE_PERIOD < 2) begin : g_bad_period
         $error("SAMPLE_PERIOD must be at least 2");
      end
      if (NUM_OSC < 1) begin : g_bad_osc
         $error("NUM_OSC must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
   endgenerate

   logic              tick;
   logic              bit_vld;
   logic              bit_val;
   logic              consume;
   logic [WORD_W-1:0] word;
   logic              ready;
   logic [WORD_W-1:0] status_word;

   oeh_sample_timer #(.SAMPLE_PERIOD(SAMPLE_PERIOD)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   oeh_osc_sampler #(.NUM_OSC(NUM_OSC), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_in (osc_in),
      .tick   (tick),
      .bit_vld(bit_vld),
      .bit_val(bit_val)
   );

   assign consume = rd_en && (rd_sel == SEL_DATA);

   oeh_word_collector #(.WORD_W(WORD_W)) u_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_vld(bit_vld),
      .bit_val(bit_val),
      .consume(consume),
      .word   (word),
      .ready  (ready)
   );

   always_comb begin
      status_word = '0;
      status_word[STATUS_READY_BIT] = ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= (rd_sel == SEL_DATA) ? word : status_word;
      end
   end
endmodule

// File: rtl/oeh_checker.sv
module oeh_checker #(
   parameter int unsigned SAMPLE_PERIOD = 4096,
   parameter int unsigned WORD_W        = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rd_sel,
   input logic [WORD_W-1:0] rd_data,
   input logic              tick,
   input logic              bit_vld,
   input logic              ready
);
   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && seen_q) |-> (gap_q == 32'(SAMPLE_PERIOD - 1)));

   assert_bit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |=> !bit_vld);

   assert_ready_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(bit_vld));

   assert_consume_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_sel) |=> !ready);

   assert_status_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_sel && ready) |=> ready);

   assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind osc_entropy_harvester oeh_checker #(
   .SAMPLE_PERIOD(SAMPLE_PERIOD),
   .WORD_W       (WORD_W)
) u_oeh_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd_en  (rd_en),
   .rd_sel (rd_sel),
   .rd_data(rd_data),
   .tick   (tick),
   .bit_vld(bit_vld),
   .ready  (ready)
);

// File: tb/osc_entropy_harvester_bench.sv
`timescale 1ns/1ps
module osc_entropy_harvester_bench;
   localparam int unsigned NOSC = 32;
   localparam int unsigned PER  = 4;
   localparam int unsigned SYNC = 2;
   localparam int unsigned WW   = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NOSC-1:0] osc_in = '0;
   logic            rd_en = 1'b0;
   logic            rd_sel = 1'b0;
   logic [WW-1:0]   rd_data;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   osc_entropy_harvester #(
      .NUM_OSC(NOSC), .SAMPLE_PERIOD(PER), .SYNC_STAGES(SYNC), .WORD_W(WW)
   ) u_osc_entropy_harvester (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   // Requirement model, stepped at each rising edge
   logic [NOSC-1:0] m_pipe [SYNC];
   int              m_cnt;
   bit              m_second, m_first, m_bvld, m_bit;
   logic [WW-1:0]   m_word, m_rd;
   int              m_fresh;
   string           m_tag = "R1";

   function automatic logic [WW-1:0] status_of(int fresh);
      logic [WW-1:0] s = '0;
      s[0] = (fresh == WW);
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
         m_cnt = 0; m_second = 0; m_first = 0; m_bvld = 0; m_bit = 0;
         m_word = '0; m_rd = '0; m_fresh = 0; m_tag = "R1";
      end else begin
         bit tick, par, n_bvld, n_bit;
         logic [WW-1:0] old_word;
         int old_fresh;
         tick = (m_cnt == PER - 1);
         par  = ^m_pipe[SYNC-1];
         old_word = m_word; old_fresh = m_fresh;
         n_bvld = tick && m_second;
         n_bit  = (tick && m_second) ? (m_first ^ par) : m_bit;
         if (tick && !m_second) m_first = par;
         if (tick) m_second = !m_second;
         if (m_bvld) m_word = {m_word[WW-2:0], m_bit};
         if (rd_en && rd_sel) m_fresh = 0;
         else if (m_bvld && m_fresh < WW) m_fresh++;
         if (rd_en) begin
            m_rd  = rd_sel ? old_word : status_of(old_fresh);
            m_tag = rd_sel ? "R6" : "R5";
         end else begin
            m_tag = "R9";
         end
         m_bvld = n_bvld; m_bit = n_bit;
         m_cnt = tick ? 0 : m_cnt + 1;
         for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
         m_pipe[0] = osc_in;
      end
   end

   task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(logic [NOSC-1:0] o, bit en, bit sel);
      osc_in = o; rd_en = en; rd_sel = sel;
      @(negedge clk);
      chk(m_tag, rd_data, m_rd);
   endtask

   task automatic hold_osc(logic [NOSC-1:0] o, int n);
      for (int i = 0; i < n; i++) step(o, 1'b0, 1'b0);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", rd_data, '0);
      step('0, 1'b1, 1'b0);
      chk("R1", rd_data, '0);

      // R2: all-zero oscillators give a zero word
      hold_osc('0, 300);
      step('0, 1'b1, 1'b0);
      chk("R5", rd_data, 32'h1);
      step('0, 1'b1, 1'b1);
      chk("R2", rd_data, '0);
      // R6: ready cleared right after the data read
      step('0, 1'b1, 1'b0);
      chk("R6", rd_data, '0);

      // R3: odd parity on every sample cancels pairwise
      hold_osc(32'h0000_0001, 300);
      step(32'h0000_0001, 1'b1, 1'b1);
      chk("R3", rd_data, '0);

      // R7 / R8: ready stays set across status reads while bits keep arriving
      for (int i = 0; i < 300; i++) step($urandom(), 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) step($urandom(), 1'b1, 1'b0);
      chk("R8", rd_data, 32'h1);
      for (int i = 0; i < 40; i++) step($urandom(), 1'b0, 1'b0);
      step($urandom(), 1'b1, 1'b1);
      chk("R7", rd_data, m_word);

      // R4 / R5 / R6 / R9: random traffic checked against the model
      for (int i = 0; i < 20000; i++) begin
         bit en = ($urandom_range(0, 7) == 0);
         step($urandom(), en, $urandom_range(0, 1) == 1);
      end
      // R4: final word read after a quiet fill
      for (int i = 0; i < 300; i++) step($urandom(), 1'b0, 1'b0);
      step($urandom(), 1'b1, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule